// File: doc/BRIEF.md
# Byte-String Multi-Register Load Sequencer

This block carries out a string-load instruction once the decoder has pulled out its fields. A request brings a destination register index, a base register index, the value of that base register, and a 5-bit immediate byte count. The sequencer forms the starting address and reads bytes one at a time from a simple memory port. It packs the returned bytes big-endian into 32-bit words and writes each finished word to the next register through a register-file write port.

The count field is a 5-bit immediate. A count of zero requests 32 bytes. Destination indices wrap from 31 back to 0. When the count is not a multiple of four, the last register gets its bytes at the top and zeros below them. The base register is never updated. A base register that falls inside the destination run is not rejected. Any byte alignment is accepted.

The sequencer takes a request only while it is idle. It reports busy from the cycle after acceptance until its one-cycle done pulse.

Top module: `strload_seq`

## Requirements
- R1: A count field of 0 loads 32 bytes, and a count of 1 to 31 loads that many bytes. A request makes exactly ceil(bytes/4) register writes.
- R2: With base index 0 the first read address is 0, whatever the base value. With any other base index the first read address is the supplied base value.
- R3: Reads go to consecutive byte addresses, one byte per read. The address steps by +1 and wraps from 0xFFFFFFFF to 0x00000000.
- R4: In each written word the first byte read sits in bits 31:24, the second in bits 23:16, the third in bits 15:8 and the fourth in bits 7:0.
- R5: When the byte count is not a multiple of 4, the final word holds the leftover bytes from bits 31:24 downward, and every unfilled lower byte is 0x00.
- R6: The first write goes to the requested destination index, and each later write goes to (previous index + 1) mod 32. A base index inside that run is written like any other register.
- R7: The starting address is captured when the request is accepted. Changing the base value input while the request is being served has no effect on the addresses read.
- R8: A request presented while busy is ignored. No writes or reads belonging to it ever appear.
- R9: After reset busy and done are 0. Busy rises the cycle after acceptance. Done is high for exactly one cycle, the cycle right after the last register write, and busy falls the cycle after done.
- R10: The register write enable is never high in two consecutive cycles. Each high cycle is one write of a 5-bit index and 32-bit data.
- R11: While a read request is pending and not yet accepted, the request stays asserted and its address stays unchanged.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_dst | input | 5 | First destination register index |
| req_base_idx | input | 5 | Base register index (0 selects address zero) |
| req_base_val | input | 32 | Contents of the base register |
| req_count | input | 5 | Immediate byte count (0 means 32) |
| mem_req_valid | output | 1 | Byte read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_addr | output | 32 | Byte address of the read |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 8 | Returned byte |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 5 | Register write index |
| rf_wdata | output | 32 | Register write data |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The properties rely on the memory side keeping one read outstanding at a time. Read data must come back no earlier than the cycle after the read request is accepted, and never when no read is waiting. The bench's memory model follows this. It returns each byte exactly one cycle after acceptance, with a deterministic data pattern built from the address. It can hold off acceptance for two of every three cycles to exercise the hold rule. Requests made during busy are stopped several cycles before the sequence ends, so no request is pending when the block becomes idle again.

// File: rtl/strload_pkg.sv
package strload_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_WRITE,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/strload_addr_gen.sv
module strload_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 5,
    parameter int CNT_W  = 5
) (
    input  logic [IDX_W-1:0]  base_idx,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [CNT_W-1:0]  count,
    output logic [ADDR_W-1:0] start_addr,
    output logic [CNT_W:0]    total_bytes
);

    localparam logic [CNT_W:0] FULL_COUNT = (CNT_W+1)'(1) << CNT_W;

    always_comb begin
        // Index zero names the literal value zero, not a register.
        start_addr  = (base_idx == '0) ? '0 : base_val;
        total_bytes = (count == '0) ? FULL_COUNT : {1'b0, count};
    end

endmodule

// File: rtl/strload_packer.sv
module strload_packer #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    localparam int LANES  = DATA_W / BYTE_W,
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [DATA_W-1:0] word_in,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [LANE_W-1:0] lane,
    output logic [DATA_W-1:0] word_out
);

    // Lane 0 is the most significant byte.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam logic [LANE_W-1:0] SEL = LANE_W'(LANES - 1 - l);
        assign word_out[(l+1)*BYTE_W-1 -: BYTE_W] =
            (lane == SEL) ? byte_in : word_in[(l+1)*BYTE_W-1 -: BYTE_W];
    end

endmodule

// File: rtl/strload_ctrl.sv
module strload_ctrl
    import strload_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int IDX_W  = 5,
    parameter int CNT_W  = 5,
    localparam int LANES  = DATA_W / BYTE_W,
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_dst,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W:0]    total_bytes,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] packed_word,
    output logic [DATA_W-1:0] word_acc,
    output logic [LANE_W-1:0] lane_sel,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              busy,
    output logic              done
);

    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W:0]    left;
        logic [LANE_W-1:0] lane;
        logic [IDX_W-1:0]  dst;
        logic [DATA_W-1:0] word;
    } seq_regs_t;

    seq_regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.st   = ST_ISSUE;
                    s_d.addr = start_addr;
                    s_d.left = total_bytes;
                    s_d.lane = '0;
                    s_d.dst  = req_dst;
                    s_d.word = '0;
                end
            end
            ST_ISSUE: begin
                if (mem_req_ready) begin
                    s_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    s_d.word = packed_word;
                    s_d.left = s_q.left - 1'b1;
                    s_d.addr = s_q.addr + 1'b1;
                    if (s_q.lane == LAST_LANE || s_q.left == (CNT_W+1)'(1)) begin
                        s_d.st = ST_WRITE;
                    end else begin
                        s_d.lane = s_q.lane + 1'b1;
                        s_d.st   = ST_ISSUE;
                    end
                end
            end
            ST_WRITE: begin
                // Index arithmetic wraps naturally at IDX_W bits.
                s_d.dst  = s_q.dst + 1'b1;
                s_d.lane = '0;
                s_d.word = '0;
                s_d.st   = (s_q.left == '0) ? ST_DONE : ST_ISSUE;
            end
            ST_DONE: begin
                s_d.st = ST_IDLE;
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, addr: '0, left: '0, lane: '0, dst: '0, word: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_req_valid = (s_q.st == ST_ISSUE);
    assign mem_addr      = s_q.addr;
    assign word_acc      = s_q.word;
    assign lane_sel      = s_q.lane;
    assign rf_we         = (s_q.st == ST_WRITE);
    assign rf_waddr      = s_q.dst;
    assign rf_wdata      = s_q.word;
    assign busy          = (s_q.st != ST_IDLE);
    assign done          = (s_q.st == ST_DONE);

endmodule

// File: rtl/strload_seq.sv
module strload_seq #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int IDX_W  = 5,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_dst,
    input  logic [IDX_W-1:0]  req_base_idx,
    input  logic [ADDR_W-1:0] req_base_val,
    input  logic [CNT_W-1:0]  req_count,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rsp_valid,
    input  logic [BYTE_W-1:0] mem_rsp_data,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              busy,
    output logic              done
);

    localparam int LANES  = DATA_W / BYTE_W;
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic [ADDR_W-1:0] start_addr;
    logic [CNT_W:0]    total_bytes;
    logic [DATA_W-1:0] word_acc;
    logic [DATA_W-1:0] packed_word;
    logic [LANE_W-1:0] lane_sel;

    strload_addr_gen #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .CNT_W  (CNT_W)
    ) addr_gen_i (
        .base_idx    (req_base_idx),
        .base_val    (req_base_val),
        .count       (req_count),
        .start_addr  (start_addr),
        .total_bytes (total_bytes)
    );

    strload_packer #(
        .DATA_W (DATA_W),
        .BYTE_W (BYTE_W)
    ) packer_i (
        .word_in  (word_acc),
        .byte_in  (mem_rsp_data),
        .lane     (lane_sel),
        .word_out (packed_word)
    );

    strload_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BYTE_W (BYTE_W),
        .IDX_W  (IDX_W),
        .CNT_W  (CNT_W)
    ) ctrl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_dst       (req_dst),
        .start_addr    (start_addr),
        .total_bytes   (total_bytes),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_addr      (mem_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .packed_word   (packed_word),
        .word_acc      (word_acc),
        .lane_sel      (lane_sel),
        .rf_we         (rf_we),
        .rf_waddr      (rf_waddr),
        .rf_wdata      (rf_wdata),
        .busy          (busy),
        .done          (done)
    );

endmodule

// File: rtl/strload_seq_chk.sv
module strload_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              rf_we,
    input logic [IDX_W-1:0]  rf_waddr,
    input logic              busy,
    input logic              done
);

    logic              seen_rd_q;
    logic [ADDR_W-1:0] last_rd_q;
    logic              seen_wr_q;
    logic [IDX_W-1:0]  last_wr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_rd_q <= 1'b0;
            last_rd_q <= '0;
            seen_wr_q <= 1'b0;
            last_wr_q <= '0;
        end else begin
            if (!busy) begin
                seen_rd_q <= 1'b0;
                seen_wr_q <= 1'b0;
            end else begin
                if (mem_req_valid && mem_req_ready) begin
                    seen_rd_q <= 1'b1;
                    last_rd_q <= mem_addr;
                end
                if (rf_we) begin
                    seen_wr_q <= 1'b1;
                    last_wr_q <= rf_waddr;
                end
            end
        end
    end

    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && seen_rd_q) |-> (mem_addr == last_rd_q + 1'b1));

    a_r6_dst_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && seen_wr_q) |-> (rf_waddr == last_wr_q + 1'b1));

    a_r8_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    a_r9_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r10_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> !rf_we);

    a_r10_we_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> busy);

    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr)));

endmodule

bind strload_seq strload_seq_chk #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_addr      (mem_addr),
    .rf_we         (rf_we),
    .rf_waddr      (rf_waddr),
    .busy          (busy),
    .done          (done)
);

// File: tb/strload_seq_tb_top.sv
`timescale 1ns/1ps
module strload_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [4:0]  req_dst = '0;
    logic [4:0]  req_base_idx = '0;
    logic [31:0] req_base_val = '0;
    logic [4:0]  req_count = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [7:0]  mem_rsp_data = '0;
    logic        rf_we;
    logic [4:0]  rf_waddr;
    logic [31:0] rf_wdata;
    logic        busy;
    logic        done;

    always #10 clk = ~clk;

    strload_seq dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_dst       (req_dst),
        .req_base_idx  (req_base_idx),
        .req_base_val  (req_base_val),
        .req_count     (req_count),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_addr      (mem_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .rf_we         (rf_we),
        .rf_waddr      (rf_waddr),
        .rf_wdata      (rf_wdata),
        .busy          (busy),
        .done          (done)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit stall_mode = 1'b0;

    logic [31:0] rd_log [0:63];
    int          rd_cnt = 0;
    logic [4:0]  wi_log [0:63];
    logic [31:0] wd_log [0:63];
    int          wr_cnt = 0;
    int          last_we_cyc = 0;
    int          done_cnt = 0;
    int          done_cyc = 0;
    int          we_back2back = 0;
    bit          we_prev = 1'b0;

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ a[31:24] ^ 8'hA5;
    endfunction

    // Memory model: one byte returned exactly one cycle after acceptance.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req_valid && mem_req_ready) begin
            if (rd_cnt < 64) rd_log[rd_cnt] <= mem_addr;
            rd_cnt        <= rd_cnt + 1;
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem_byte(mem_addr);
        end else begin
            mem_rsp_valid <= 1'b0;
        end
        mem_req_ready <= stall_mode ? ((cyc % 3) == 0) : 1'b1;
        if (rf_we) begin
            if (wr_cnt < 64) begin
                wi_log[wr_cnt] <= rf_waddr;
                wd_log[wr_cnt] <= rf_wdata;
            end
            wr_cnt      <= wr_cnt + 1;
            last_we_cyc <= cyc;
        end
        if (rf_we && we_prev) we_back2back <= we_back2back + 1;
        we_prev <= rf_we;
        if (done) begin
            done_cnt <= done_cnt + 1;
            done_cyc <= cyc;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic run_req(input logic [4:0] dst, input logic [4:0] bidx,
                           input logic [31:0] bval, input logic [4:0] cnt,
                           input bit stall, input bit scramble, input bit hammer,
                           input string tag);
        int n;
        int nw;
        logic [31:0] start;
        int bad_a, bad_i, bad_d;
        logic [31:0] act_a, exp_a, act_d, exp_d;
        int waited;
        @(negedge clk);
        while (busy) @(negedge clk);
        stall_mode = stall;
        rd_cnt = 0; wr_cnt = 0; done_cnt = 0; we_back2back = 0;
        n = (cnt == 0) ? 32 : int'(cnt);
        nw = (n + 3) / 4;
        start = (bidx == 0) ? 32'h0 : bval;
        req_dst = dst; req_base_idx = bidx; req_base_val = bval; req_count = cnt;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, {"R9 busy after accept ", tag}, 32'(busy), 32'd1);
        if (scramble) req_base_val = ~bval;
        if (hammer) begin
            for (int k = 0; k < 6; k++) begin
                req_valid = 1'b1; req_dst = dst ^ 5'h15; req_count = 5'd31;
                req_base_idx = 5'd7; req_base_val = 32'h0BAD_0000;
                @(negedge clk);
            end
            req_valid = 1'b0;
        end
        waited = 0;
        while (done_cnt == 0 && waited < 4000) begin
            @(negedge clk);
            waited++;
        end
        chk(waited < 4000, {"R9 watchdog on done ", tag}, 32'(waited), 32'd0);
        @(negedge clk);
        chk(busy == 1'b0, {"R9 busy falls after done ", tag}, 32'(busy), 32'd0);
        repeat (3) @(negedge clk);
        chk(wr_cnt == nw, {"R1 write count ", tag}, 32'(wr_cnt), 32'(nw));
        chk(rd_cnt == n, {"R3 read count ", tag}, 32'(rd_cnt), 32'(n));
        chk(rd_cnt > 0 && rd_log[0] == start, {"R2 first address ", tag},
            rd_log[0], start);
        bad_a = 0; act_a = 0; exp_a = 0;
        for (int k = 0; k < n && k < rd_cnt && k < 64; k++) begin
            if (rd_log[k] !== start + 32'(k)) begin
                if (bad_a == 0) begin act_a = rd_log[k]; exp_a = start + 32'(k); end
                bad_a++;
            end
        end
        chk(bad_a == 0, {"R3 R7 address sequence ", tag}, act_a, exp_a);
        bad_i = 0; bad_d = 0; act_d = 0; exp_d = 0;
        for (int w = 0; w < nw && w < wr_cnt && w < 64; w++) begin
            logic [31:0] ew;
            logic [4:0]  ei;
            ew = '0;
            for (int j = 0; j < 4; j++) begin
                if (w*4 + j < n) ew[31 - 8*j -: 8] = mem_byte(start + 32'(w*4 + j));
            end
            ei = dst + 5'(w);
            if (wi_log[w] !== ei) bad_i++;
            if (wd_log[w] !== ew) begin
                if (bad_d == 0) begin act_d = wd_log[w]; exp_d = ew; end
                bad_d++;
            end
        end
        chk(bad_i == 0, {"R6 destination indices ", tag}, 32'(bad_i), 32'd0);
        chk(bad_d == 0, {"R4 R5 packed data ", tag}, act_d, exp_d);
        chk(done_cnt == 1, {"R9 done pulse count ", tag}, 32'(done_cnt), 32'd1);
        chk(done_cyc == last_we_cyc + 1, {"R9 done follows last write ", tag},
            32'(done_cyc), 32'(last_we_cyc + 1));
        chk(we_back2back == 0, {"R10 single-cycle writes ", tag},
            32'(we_back2back), 32'd0);
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R9 reset busy", 32'(busy), 32'd0);
        chk(done == 1'b0, "R9 reset done", 32'(done), 32'd0);
        chk(rf_we == 1'b0, "R10 reset write enable", 32'(rf_we), 32'd0);
        chk(mem_req_valid == 1'b0, "R11 reset read request", 32'(mem_req_valid), 32'd0);
    endtask

    // R1: zero count means a full 32-byte load.
    task automatic t_full_count();
        run_req(5'd4, 5'd3, 32'h0000_1000, 5'd0, 1'b0, 1'b0, 1'b0, "count0");
    endtask

    // R2: base index zero ignores the supplied value.
    task automatic t_base_zero();
        run_req(5'd10, 5'd0, 32'hDEAD_BEEF, 5'd5, 1'b0, 1'b0, 1'b0, "base0");
    endtask

    // R3: address wraps across the top of the address space.
    task automatic t_addr_wrap();
        run_req(5'd1, 5'd2, 32'hFFFF_FFFD, 5'd7, 1'b0, 1'b0, 1'b0, "addrwrap");
    endtask

    // R6: destination wraps from 31 to 0, base index inside the run.
    task automatic t_dst_wrap();
        run_req(5'd30, 5'd0, 32'h0, 5'd12, 1'b0, 1'b0, 1'b0, "dstwrap");
        run_req(5'd29, 5'd31, 32'h0000_0203, 5'd16, 1'b0, 1'b0, 1'b0, "baseinrange");
    endtask

    // R5: every leftover length, including a single byte.
    task automatic t_partials();
        run_req(5'd0, 5'd5, 32'h0000_0040, 5'd1, 1'b0, 1'b0, 1'b0, "len1");
        run_req(5'd8, 5'd5, 32'h0000_0041, 5'd2, 1'b0, 1'b0, 1'b0, "len2");
        run_req(5'd16, 5'd5, 32'h0000_0043, 5'd3, 1'b0, 1'b0, 1'b0, "len3");
        run_req(5'd20, 5'd5, 32'h0000_0047, 5'd4, 1'b0, 1'b0, 1'b0, "len4");
        run_req(5'd24, 5'd5, 32'h1234_5679, 5'd31, 1'b0, 1'b0, 1'b0, "len31");
    endtask

    // R7: base value changes after acceptance.
    task automatic t_latched();
        run_req(5'd12, 5'd9, 32'h8000_0010, 5'd9, 1'b0, 1'b1, 1'b0, "latched");
    endtask

    // R8: requests while busy are dropped.
    task automatic t_busy_ignore();
        run_req(5'd3, 5'd6, 32'h0000_5000, 5'd13, 1'b0, 1'b0, 1'b1, "busyreq");
    endtask

    // R11: memory holds off acceptance.
    task automatic t_stall();
        run_req(5'd18, 5'd4, 32'h0000_7FFE, 5'd10, 1'b1, 1'b0, 1'b0, "stall");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_count();
        t_base_zero();
        t_addr_wrap();
        t_dst_wrap();
        t_partials();
        t_latched();
        t_busy_ignore();
        t_stall();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule